// File: doc/BRIEF.md
# Multi-Cycle 16-bit Processor Core

This block is a small 16-bit processor core. A Moore-style control state machine steps one shared datapath through fetch, decode and execute states. The datapath holds an eight-entry register file, an instruction register, a program counter, and a single ALU. That ALU also computes the incremented program counter during fetch and the branch target during decode. Instructions and data live in one unified memory reached through a single port. The core drives address, read strobe, write strobe and write data on that port, and it takes read data back combinationally in the same cycle.

Every instruction is 16 bits wide, with the opcode in bits [15:13]. The register format puts the first source at [12:10], the second source at [9:7], the destination at [6:4] and the function code at [3:0]. The immediate format keeps both source fields and places a 7-bit two's-complement offset at [6:0]. The jump format carries a 13-bit target at [12:0]. Most instructions take three cycles. Loads and stores take four, because address computation and memory access each need their own cycle on the shared port. No-ops take two cycles. A halt instruction parks the core until reset.

Top module: `mc16_core`

## Requirements
- R1: While reset (active-low `rst_n`) is held, the core sits in fetch with PC 0: `mem_addr` is 0, `mem_rd` is 1, `mem_wr` is 0 and `halted` is 0.
- R2: Each fetch drives the PC on `mem_addr` with `mem_rd` high, loads the word into the instruction register and writes PC+1 back. It is always followed by one decode cycle with no memory access, so successive fetches of straight-line code use addresses 0, 1, 2.
- R3: Opcode 0 with function code 0, 1, 2 or 3 writes rs+rt, rs-rt, rs AND rt or rs OR rt (16-bit, wrapping) to rd.
- R4: Opcode 0 with function code 4 writes 1 to rd when rs is less than rt as signed 16-bit values, and 0 otherwise.
- R5: Opcode 4 writes rs plus the sign-extended 7-bit offset to rt.
- R6: Opcode 1 loads rt from memory at rs plus the sign-extended offset and takes four cycles.
- R7: Opcode 2 writes rt to memory at rs plus the sign-extended offset. `mem_wr` is high for exactly one cycle, and the instruction takes four cycles.
- R8: Opcode 3 sets PC to (address of the beq)+1+sign-extended offset when rs equals rt, and otherwise falls through. Either way it takes three cycles, and negative offsets branch backwards.
- R9: Opcode 5 sets PC to the 13-bit target, zero-extended, in three cycles. The instructions it skips have no effect.
- R10: Opcode 7 raises `halted` two cycles after its fetch begins. `halted` then stays high, with `mem_rd` and `mem_wr` low, until reset.
- R11: Opcode 6, and opcode 0 with a function code from 5 to 15, change no register and take two cycles.
- R12: Register-format operations and opcodes 4 and 5 each take three cycles, and `mem_rd` and `mem_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 16 | Word address for fetch, load or store |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Store data |
| mem_rdata | input | 16 | Read data, valid in the same cycle as the address |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
The ALU operations are tried with one positive and one negative operand, so that the signed and unsigned comparisons give different results and a truncated or zero-extended immediate shows up. Memory access runs with a base register plus negative and positive offsets, and a load result is added and stored back, which separates the address arithmetic from the data path. Control flow is covered by a taken and a not-taken forward branch, a backward loop, and a jump over a store. Cycle counts for each program are compared with the per-class costs, which exposes any added or dropped state. A short program of no-ops and a halt probes the fetch address sequence cycle by cycle.

// File: rtl/mc16_pkg.sv
package mc16_pkg;

   typedef enum logic [2:0] {
      OP_RTYPE = 3'd0, OP_LOAD = 3'd1, OP_STORE = 3'd2, OP_BEQ  = 3'd3,
      OP_ADDI  = 3'd4, OP_JUMP = 3'd5, OP_NOP   = 3'd6, OP_HALT = 3'd7
   } opcode_e;

   typedef enum logic [2:0] {
      ALU_ADD = 3'd0, ALU_SUB = 3'd1, ALU_AND = 3'd2, ALU_OR = 3'd3, ALU_SLT = 3'd4
   } alu_op_e;

   typedef enum logic [1:0] {
      SRCB_ONE, SRCB_REG, SRCB_IMM
   } srcb_e;

   typedef enum logic [3:0] {
      ST_FETCH, ST_DECODE, ST_EXEC_R, ST_EXEC_ADDI, ST_EXEC_BEQ,
      ST_EXEC_JUMP, ST_ADDR, ST_MEM_LD, ST_MEM_ST, ST_HALT
   } state_e;

   typedef struct packed {
      logic    ir_ld;
      logic    ab_ld;
      logic    tgt_ld;
      logic    mar_ld;
      logic    pc_inc;
      logic    pc_br;
      logic    pc_jmp;
      logic    rf_we;
      logic    rf_to_rd;
      logic    rf_from_mem;
      logic    mem_rd;
      logic    mem_wr;
      logic    addr_mar;
      logic    a_is_pc;
      srcb_e   b_sel;
      alu_op_e alu_op;
      logic    halted;
   } ctl_t;

endpackage

// File: rtl/mc16_alu.sv
module mc16_alu
   import mc16_pkg::*;
#(
   parameter int W          = 16,
   parameter bit SLT_SIGNED = 1'b1
) (
   input  alu_op_e        op,
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   output logic [W-1:0]   y,
   output logic           zero
);
   logic lt;

   generate
      if (SLT_SIGNED) begin : g_lt_signed
         assign lt = $signed(a) < $signed(b);
      end else begin : g_lt_unsigned
         assign lt = a < b;
      end
   endgenerate

   always_comb begin
      case (op)
         ALU_SUB: y = a - b;
         ALU_AND: y = a & b;
         ALU_OR:  y = a | b;
         ALU_SLT: y = {{(W-1){1'b0}}, lt};
         default: y = a + b;
      endcase
   end

   assign zero = (y == '0);
endmodule

// File: rtl/mc16_regfile.sv
module mc16_regfile #(
   parameter int W     = 16,
   parameter int NREGS = 8,
   localparam int AW   = $clog2(NREGS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] ra_addr,
   input  logic [AW-1:0] rb_addr,
   output logic [W-1:0]  ra_data,
   output logic [W-1:0]  rb_data,
   input  logic          we,
   input  logic [AW-1:0] wa,
   input  logic [W-1:0]  wd
);
   logic [W-1:0] regs [NREGS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NREGS; i++) regs[i] <= '0;
      end else if (we) begin
         regs[wa] <= wd;
      end
   end

   assign ra_data = regs[ra_addr];
   assign rb_data = regs[rb_addr];
endmodule

// File: rtl/mc16_ctrl.sv
module mc16_ctrl
   import mc16_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  opcode_e    opcode,
   input  logic [3:0] funct,
   input  logic       alu_zero,
   output state_e     state,
   output ctl_t       ctl
);
   state_e nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_FETCH;
      else        state <= nxt;
   end

   always_comb begin
      nxt = ST_FETCH;
      case (state)
         ST_FETCH:  nxt = ST_DECODE;
         ST_DECODE: begin
            case (opcode)
               OP_RTYPE: nxt = (funct <= 4'd4) ? ST_EXEC_R : ST_FETCH;
               OP_LOAD,
               OP_STORE: nxt = ST_ADDR;
               OP_BEQ:   nxt = ST_EXEC_BEQ;
               OP_ADDI:  nxt = ST_EXEC_ADDI;
               OP_JUMP:  nxt = ST_EXEC_JUMP;
               OP_HALT:  nxt = ST_HALT;
               default:  nxt = ST_FETCH;
            endcase
         end
         ST_ADDR:   nxt = (opcode == OP_LOAD) ? ST_MEM_LD : ST_MEM_ST;
         ST_HALT:   nxt = ST_HALT;
         default:   nxt = ST_FETCH;
      endcase
   end

   always_comb begin
      ctl        = '0;
      ctl.b_sel  = SRCB_REG;
      ctl.alu_op = ALU_ADD;
      case (state)
         ST_FETCH: begin
            ctl.mem_rd  = 1'b1;
            ctl.ir_ld   = 1'b1;
            ctl.a_is_pc = 1'b1;
            ctl.b_sel   = SRCB_ONE;
            ctl.pc_inc  = 1'b1;
         end
         ST_DECODE: begin
            ctl.ab_ld   = 1'b1;
            ctl.tgt_ld  = 1'b1;
            ctl.a_is_pc = 1'b1;
            ctl.b_sel   = SRCB_IMM;
         end
         ST_EXEC_R: begin
            ctl.alu_op   = alu_op_e'(funct[2:0]);
            ctl.rf_we    = 1'b1;
            ctl.rf_to_rd = 1'b1;
         end
         ST_EXEC_ADDI: begin
            ctl.b_sel = SRCB_IMM;
            ctl.rf_we = 1'b1;
         end
         ST_EXEC_BEQ: begin
            ctl.alu_op = ALU_SUB;
            ctl.pc_br  = alu_zero;
         end
         ST_EXEC_JUMP: ctl.pc_jmp = 1'b1;
         ST_ADDR: begin
            ctl.b_sel  = SRCB_IMM;
            ctl.mar_ld = 1'b1;
         end
         ST_MEM_LD: begin
            ctl.addr_mar    = 1'b1;
            ctl.mem_rd      = 1'b1;
            ctl.rf_we       = 1'b1;
            ctl.rf_from_mem = 1'b1;
         end
         ST_MEM_ST: begin
            ctl.addr_mar = 1'b1;
            ctl.mem_wr   = 1'b1;
         end
         ST_HALT: ctl.halted = 1'b1;
         default: ;
      endcase
   end
endmodule

// File: rtl/mc16_core.sv
module mc16_core
   import mc16_pkg::*;
#(
   parameter int W          = 16,
   parameter int NREGS      = 8,
   parameter bit SLT_SIGNED = 1'b1,
   localparam int RAW       = $clog2(NREGS),
   localparam int IMM_W     = 7,
   localparam int TGT_W     = 13
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] mem_addr,
   output logic         mem_rd,
   output logic         mem_wr,
   output logic [W-1:0] mem_wdata,
   input  logic [W-1:0] mem_rdata,
   output logic         halted
);
   generate
      if (W != 16) begin : g_bad_width
         $error("mc16_core: the instruction encoding requires W == 16");
      end
      if (NREGS != 8) begin : g_bad_regs
         $error("mc16_core: register fields are 3 bits, NREGS must be 8");
      end
   endgenerate

   state_e state_q;
   ctl_t   ctl;

   logic [W-1:0] ir_q, pc_q, a_q, b_q, tgt_q, mar_q;
   logic [W-1:0] imm, alu_a, alu_b, alu_y, rf_a, rf_b, rf_wd;
   logic [RAW-1:0] rf_wa;
   logic alu_zero;

   assign imm = {{(W-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};

   mc16_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .opcode   (opcode_e'(ir_q[15:13])),
      .funct    (ir_q[3:0]),
      .alu_zero (alu_zero),
      .state    (state_q),
      .ctl      (ctl)
   );

   assign alu_a = ctl.a_is_pc ? pc_q : a_q;
   always_comb begin
      case (ctl.b_sel)
         SRCB_ONE: alu_b = {{(W-1){1'b0}}, 1'b1};
         SRCB_IMM: alu_b = imm;
         default:  alu_b = b_q;
      endcase
   end

   mc16_alu #(.W(W), .SLT_SIGNED(SLT_SIGNED)) u_alu (
      .op   (ctl.alu_op),
      .a    (alu_a),
      .b    (alu_b),
      .y    (alu_y),
      .zero (alu_zero)
   );

   assign rf_wa = ctl.rf_to_rd ? ir_q[6:4] : ir_q[9:7];
   assign rf_wd = ctl.rf_from_mem ? mem_rdata : alu_y;

   mc16_regfile #(.W(W), .NREGS(NREGS)) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .ra_addr (ir_q[12:10]),
      .rb_addr (ir_q[9:7]),
      .ra_data (rf_a),
      .rb_data (rf_b),
      .we      (ctl.rf_we),
      .wa      (rf_wa),
      .wd      (rf_wd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ir_q  <= '0;
         pc_q  <= '0;
         a_q   <= '0;
         b_q   <= '0;
         tgt_q <= '0;
         mar_q <= '0;
      end else begin
         if (ctl.ir_ld)  ir_q  <= mem_rdata;
         if (ctl.ab_ld)  begin a_q <= rf_a; b_q <= rf_b; end
         if (ctl.tgt_ld) tgt_q <= alu_y;
         if (ctl.mar_ld) mar_q <= alu_y;
         if (ctl.pc_inc)      pc_q <= alu_y;
         else if (ctl.pc_br)  pc_q <= tgt_q;
         else if (ctl.pc_jmp) pc_q <= {{(W-TGT_W){1'b0}}, ir_q[TGT_W-1:0]};
      end
   end

   assign mem_addr  = ctl.addr_mar ? mar_q : pc_q;
   assign mem_rd    = ctl.mem_rd;
   assign mem_wr    = ctl.mem_wr;
   assign mem_wdata = b_q;
   assign halted    = ctl.halted;
endmodule

// File: rtl/mc16_core_chk.sv
module mc16_core_chk
   import mc16_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic        mem_rd,
   input logic        mem_wr,
   input logic        halted,
   input state_e      state,
   input logic [15:0] pc
);
   p_rd_wr_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   p_fetch_then_decode_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FETCH) |=> (state == ST_DECODE));

   p_fetch_inc_pc_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FETCH) |=> (pc == $past(pc) + 16'd1));

   p_halt_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted);

   p_halt_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> (!mem_rd && !mem_wr));

   p_store_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |=> !mem_wr);
endmodule

bind mc16_core mc16_core_chk u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .mem_rd (mem_rd),
   .mem_wr (mem_wr),
   .halted (halted),
   .state  (state_q),
   .pc     (pc_q)
);

// File: tb/mc16_core_tb_top.sv
module mc16_core_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] mem_addr, mem_wdata, mem_rdata;
   logic        mem_rd, mem_wr, halted;
   logic [15:0] mem [256];
   int checks = 0;
   int errors = 0;
   int wr_count = 0;

   always #10 clk = ~clk;

   mc16_core dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .mem_addr  (mem_addr),
      .mem_rd    (mem_rd),
      .mem_wr    (mem_wr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .halted    (halted)
   );

   assign mem_rdata = mem[mem_addr[7:0]];

   always @(posedge clk) begin
      if (rst_n && mem_wr) begin
         mem[mem_addr[7:0]] <= mem_wdata;
         wr_count <= wr_count + 1;
      end
   end

   function automatic logic [15:0] enc_r(int rs, int rt, int rd, int f);
      return {3'd0, 3'(rs), 3'(rt), 3'(rd), 4'(f)};
   endfunction
   function automatic logic [15:0] enc_i(int op, int rs, int rt, int off);
      return {3'(op), 3'(rs), 3'(rt), 7'(off)};
   endfunction
   function automatic logic [15:0] enc_j(int tgt);
      return {3'd5, 13'(tgt)};
   endfunction
   localparam logic [15:0] HALT = 16'hE000;
   localparam logic [15:0] NOP  = 16'hC000;

   task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 256; i++) mem[i] = 16'h0;
   endtask

   task automatic hold_reset();
      @(negedge clk);
      rst_n = 1'b0;
      wr_count = 0;
      @(negedge clk);
   endtask

   task automatic run(output int cycles);
      cycles = 0;
      @(negedge clk);
      rst_n = 1'b1;
      while (cycles < 2000) begin
         @(posedge clk);
         cycles++;
         @(negedge clk);
         if (halted) break;
      end
   endtask

   task automatic t_reset_halt();
      int cyc;
      clear_mem();
      mem[0] = HALT;
      hold_reset();
      check("R1 mem_addr in reset", mem_addr, 16'd0);
      check("R1 mem_rd in reset", {15'd0, mem_rd}, 16'd1);
      check("R1 mem_wr in reset", {15'd0, mem_wr}, 16'd0);
      check("R1 halted in reset", {15'd0, halted}, 16'd0);
      run(cyc);
      check("R10 halt latency", 16'(cyc), 16'd2);
      repeat (10) @(negedge clk);
      check("R10 halted sticky", {15'd0, halted}, 16'd1);
      check("R10 no access while halted", {14'd0, mem_rd, mem_wr}, 16'd0);
   endtask

   task automatic t_fetch_seq();
      clear_mem();
      mem[0] = NOP; mem[1] = NOP; mem[2] = HALT;
      hold_reset();
      @(negedge clk);
      rst_n = 1'b1;
      for (int k = 0; k < 3; k++) begin
         check("R2 fetch address", mem_addr, 16'(k));
         check("R2 fetch strobe", {14'd0, mem_rd, mem_wr}, 16'd2);
         @(negedge clk);
         check("R2 decode idle", {14'd0, mem_rd, mem_wr}, 16'd0);
         @(negedge clk);
      end
      check("R10 halted after nops", {15'd0, halted}, 16'd1);
   endtask

   task automatic t_alu();
      int cyc;
      clear_mem();
      mem[0]  = enc_i(4, 0, 1, 25);
      mem[1]  = enc_i(4, 0, 2, -7);
      mem[2]  = enc_r(1, 2, 3, 0);
      mem[3]  = enc_r(1, 2, 4, 1);
      mem[4]  = enc_r(1, 2, 5, 2);
      mem[5]  = enc_r(1, 2, 6, 3);
      mem[6]  = enc_r(2, 1, 7, 4);
      mem[7]  = enc_i(2, 0, 3, 40);
      mem[8]  = enc_i(2, 0, 4, 41);
      mem[9]  = enc_i(2, 0, 5, 42);
      mem[10] = enc_i(2, 0, 6, 43);
      mem[11] = enc_i(2, 0, 7, 44);
      mem[12] = enc_r(1, 2, 3, 4);
      mem[13] = enc_i(2, 0, 3, 45);
      mem[14] = HALT;
      hold_reset();
      run(cyc);
      check("R3 add", mem[40], 16'd18);
      check("R3 sub", mem[41], 16'd32);
      check("R3 and", mem[42], 16'h0019);
      check("R3 or / R5 negative imm", mem[43], 16'hFFF9);
      check("R4 slt negative<positive", mem[44], 16'd1);
      check("R4 slt positive<negative", mem[45], 16'd0);
      check("R12 cycle count", 16'(cyc), 16'(2*3 + 6*3 + 6*4 + 2));
   endtask

   task automatic t_ldst();
      int cyc;
      clear_mem();
      mem[60] = 16'h1234; mem[61] = 16'hBEEF;
      mem[0] = enc_i(4, 0, 1, 62);
      mem[1] = enc_i(1, 1, 2, -2);
      mem[2] = enc_i(1, 1, 3, -1);
      mem[3] = enc_r(2, 3, 4, 0);
      mem[4] = enc_i(2, 1, 4, 1);
      mem[5] = enc_i(2, 1, 2, 2);
      mem[6] = HALT;
      hold_reset();
      run(cyc);
      check("R6 load sum stored", mem[63], 16'hD123);
      check("R7 store positive offset", mem[64], 16'h1234);
      check("R7 one write per store", 16'(wr_count), 16'd2);
      check("R6 cycle count", 16'(cyc), 16'(3 + 4 + 4 + 3 + 4 + 4 + 2));
   endtask

   task automatic t_branch_jump();
      int cyc;
      clear_mem();
      mem[0]  = enc_i(4, 0, 1, 3);
      mem[1]  = enc_i(4, 0, 2, 3);
      mem[2]  = enc_i(3, 1, 2, 2);
      mem[3]  = enc_i(4, 0, 3, 1);
      mem[4]  = enc_i(4, 0, 3, 2);
      mem[5]  = enc_i(4, 0, 4, 9);
      mem[6]  = enc_i(3, 1, 0, 1);
      mem[7]  = enc_i(4, 0, 5, 4);
      mem[8]  = enc_i(2, 0, 3, 50);
      mem[9]  = enc_i(2, 0, 4, 51);
      mem[10] = enc_i(2, 0, 5, 52);
      mem[11] = enc_j(13);
      mem[12] = enc_i(2, 0, 1, 53);
      mem[13] = HALT;
      hold_reset();
      run(cyc);
      check("R8 taken beq skips", mem[50], 16'd0);
      check("R8 taken beq target", mem[51], 16'd9);
      check("R8 not-taken beq falls through", mem[52], 16'd4);
      check("R9 jump skips store", mem[53], 16'd0);
      check("R9 cycle count", 16'(cyc), 16'(6 + 3 + 3 + 3 + 3 + 12 + 3 + 2));
   endtask

   task automatic t_loop();
      int cyc;
      clear_mem();
      mem[0] = enc_i(4, 0, 1, 4);
      mem[1] = enc_i(4, 0, 2, 0);
      mem[2] = enc_i(4, 2, 2, 5);
      mem[3] = enc_i(4, 1, 1, -1);
      mem[4] = enc_i(3, 1, 0, 1);
      mem[5] = enc_i(3, 0, 0, -4);
      mem[6] = enc_i(2, 0, 2, 55);
      mem[7] = HALT;
      hold_reset();
      run(cyc);
      check("R8 backward loop result", mem[55], 16'd20);
      check("R8 loop cycle count", 16'(cyc), 16'(6 + 4*9 + 3*3 + 4 + 2));
   endtask

   task automatic t_nop();
      int cyc;
      clear_mem();
      mem[0] = enc_i(4, 0, 1, 7);
      mem[1] = NOP;
      mem[2] = enc_r(0, 0, 1, 9);
      mem[3] = enc_i(2, 0, 1, 56);
      mem[4] = HALT;
      hold_reset();
      run(cyc);
      check("R11 no-ops leave register", mem[56], 16'd7);
      check("R11 cycle count", 16'(cyc), 16'(3 + 2 + 2 + 4 + 2));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      t_reset_halt();
      t_fetch_seq();
      t_alu();
      t_ldst();
      t_branch_jump();
      t_loop();
      t_nop();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule